// File: doc/BRIEF.md
# Interrupt Collector with Memory-Write Delivery

The block gathers 32 level interrupt lines into one register bank on a 32-bit slave port. It does not drive an interrupt pin. When an enabled line rises it sends one 32-bit write on a simple master port. The write's address is the target register with its low five bits cleared. Its data is those five bits, zero-extended, so a processor can hand each interrupt to a slot in memory. Software sees:

- a request register, which holds latched enabled sources;
- a mask register;
- a pending register, which records every rise and clears when it is read;
- a control register, where bit 8 inhibits message delivery;
- the target register;
- a write-one-to-clear alias of the request register.

Messages that meet a busy master port wait in a short in-order queue. Line use by convention:

| Source | Line |
|---|---|
| serial | 5 |
| parallel | 7 |
| network | 8 |
| disk controller | 9 |
| audio | 13 |
| the collector itself | 14 |
| keyboard and mouse (shared) | 26 |

Top module: `irq_msg_agg`

## Requirements
- R1: After reset the request, mask, pending and control registers read zero, the target register reads TGT_BASE+3, no message is offered and both sticky flags are low.
- R2: Offset 0x00 returns the request register and ignores writes.
- R3: A 0-to-1 change on line n, sampled on a clock edge, sets pending bit n. A line held high does not set it again or send another message.
- R4: A rise on line n sets request bit n only when mask bit n is 1. A rise on a masked-off line sends no message.
- R5: Each cycle in which at least one enabled line rises queues one message. The message address is target[31:5] with bits 4:0 zero, and its data is target[4:0] in bits 4:0 with all other bits zero.
- R6: While control bit 8 is 1, no message is queued, although request and pending still latch. A read of offset 0x0C returns only bit 8, and every other bit reads zero.
- R7: Any read of offset 0x08 returns the pending value and clears it. Any write there clears it. A rise in the same cycle as the clearing access stays set.
- R8: Queued messages leave in arrival order. Address and data hold steady while valid is high and ready is low.
- R9: The queue holds Q_DEPTH (default 4) messages. A message arriving while it is full is dropped, and a sticky overflow flag goes high.
- R10: An access to any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 or 0x14 answers with the error bit set and read data zero.
- R11: Mask writes always store the data. The sticky illegal-mask flag goes high when the data has a bit outside {5,7,8,9,13,14,16..21,26} and is not all ones.
- R12: Writing a 1 to a bit at offset 0x14 clears that request bit. A read of 0x14 returns the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 32 | Interrupt lines, synchronous to clk |
| bus_req_i | input | 1 | Slave access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_ack_o | output | 1 | Access completed, one cycle after the strobe |
| bus_rdata_o | output | 32 | Read data, valid with ack |
| bus_err_o | output | 1 | Undecoded offset, valid with ack |
| msg_valid_o | output | 1 | Message write offered |
| msg_addr_o | output | 32 | Message address, 32-byte aligned |
| msg_data_o | output | 32 | Message data, line code in bits 4:0 |
| msg_ready_i | input | 1 | Master side accepts the message |
| bad_mask_o | output | 1 | Sticky illegal-mask flag |
| msg_ovf_o | output | 1 | Sticky queue overflow flag |

## Verification
Every slave access is sampled at the clock edge that sees the strobe. Its response and its effect on registers are visible one edge later. The bench therefore raises the strobe at a falling edge and reads ack, data and error at the next falling edge.

A line rise seen at edge t sets pending and request and raises message valid right after that same edge. The first falling edge after t is where the bench checks the address and data of the message, and also checks that valid stays low when delivery is inhibited or the line is masked off.

A message leaves at the edge where ready is high. The queue order is therefore checked by holding ready for exactly one cycle per message and comparing each head at the falling edge in between.

// File: rtl/irq_agg_pkg.sv
// Package: shared constants, register offsets and the offset decoder for
// the interrupt collector. Assumes a 32-bit data path and 8-bit byte offsets.
package irq_agg_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned OFS_W    = 8;
    localparam int unsigned CODE_W   = 5;
    localparam int unsigned INHIB_B  = 8;

    localparam logic [OFS_W-1:0] OFS_REQ     = 8'h00;
    localparam logic [OFS_W-1:0] OFS_MASK    = 8'h04;
    localparam logic [OFS_W-1:0] OFS_PEND    = 8'h08;
    localparam logic [OFS_W-1:0] OFS_CTRL    = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_TGT     = 8'h10;
    localparam logic [OFS_W-1:0] OFS_REQ_CLR = 8'h14;

    // Lines a mask write may legally enable: 5,7,8,9,13,14,16..21,26.
    localparam logic [DATA_W-1:0] LEGAL_MASK = 32'h043F_63A0;

    // Conventional line use.
    localparam int unsigned LINE_SERIAL  = 5;
    localparam int unsigned LINE_PARPORT = 7;
    localparam int unsigned LINE_NET     = 8;
    localparam int unsigned LINE_DISK    = 9;
    localparam int unsigned LINE_AUDIO   = 13;
    localparam int unsigned LINE_SELF    = 14;
    localparam int unsigned LINE_KBDMOU  = 26;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_REQ,
        SEL_MASK,
        SEL_PEND,
        SEL_CTRL,
        SEL_TGT,
        SEL_REQ_CLR
    } reg_sel_e;

    // Map a byte offset onto the register it selects.
    function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] a);
        case (a)
            OFS_REQ:     return SEL_REQ;
            OFS_MASK:    return SEL_MASK;
            OFS_PEND:    return SEL_PEND;
            OFS_CTRL:    return SEL_CTRL;
            OFS_TGT:     return SEL_TGT;
            OFS_REQ_CLR: return SEL_REQ_CLR;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_rise_det.sv
// Rising-edge detector: one flop per line remembers the previous level and
// a pulse marks each 0-to-1 change. Assumes lines are synchronous to clk.
module irq_rise_det #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        // Track the level seen at the last edge for line i.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= lvl_i[i];
        end
        assign rise_o[i] = lvl_i[i] & ~prev_q[i];
    end

endmodule

// File: rtl/irq_agg_regs.sv
// Register bank: decodes the slave port, latches line rises into the
// pending and request registers and raises a push toward the message
// queue. Assumes single-cycle accesses, responded to one cycle later.
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter logic [DATA_W-1:0] TGT_BASE = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [OFS_W-1:0]  addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] rise_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o,
    output logic              push_o,
    output logic [DATA_W-1:0] push_word_o,
    output logic              bad_mask_o
);

    localparam logic [DATA_W-1:0] CTRL_RD_MASK = DATA_W'(1) << INHIB_B;

    reg_sel_e          sel, sel_q;
    logic              wr, rd, rd_q;
    logic [DATA_W-1:0] irr_q, imr_q, pend_q, ctrl_q, tgt_q;
    logic [DATA_W-1:0] enabled, rd_mux, clr_bits;
    logic              mask_illegal;

    assign sel     = decode_ofs(addr_i);
    assign wr      = req_i & we_i;
    assign rd      = req_i & ~we_i;
    assign enabled = rise_i & imr_q;

    // Bits to strip from the request register through the clear alias.
    assign clr_bits = (wr && sel == SEL_REQ_CLR) ? wdata_i : '0;

    // Legality of the mask data presented with a mask write.
    assign mask_illegal = ((wdata_i & ~LEGAL_MASK) != '0) && (wdata_i != '1);

    // Request register: set by enabled rises, cleared only via the alias.
    always_ff @(posedge clk) begin
        if (!rst_n) irr_q <= '0;
        else        irr_q <= (irr_q & ~clr_bits) | enabled;
    end

    // Mask register: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                     imr_q <= '0;
        else if (wr && sel == SEL_MASK) imr_q <= wdata_i;
    end

    // Pending register: any access clears it, a same-cycle rise survives.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= ((req_i && sel == SEL_PEND) ? '0 : pend_q) | rise_i;
    end

    // Control register: stores the full word, only bit 8 acts.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ctrl_q <= '0;
        else if (wr && sel == SEL_CTRL) ctrl_q <= wdata_i;
    end

    // Target register: address and line code of outgoing messages.
    always_ff @(posedge clk) begin
        if (!rst_n)                    tgt_q <= TGT_BASE + DATA_W'(3);
        else if (wr && sel == SEL_TGT) tgt_q <= wdata_i;
    end

    // Sticky flag for mask writes outside the legal set.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     bad_mask_o <= 1'b0;
        else if (wr && sel == SEL_MASK && mask_illegal) bad_mask_o <= 1'b1;
    end

    // Read multiplexer over the decoded register.
    always_comb begin
        case (sel)
            SEL_REQ, SEL_REQ_CLR: rd_mux = irr_q;
            SEL_MASK:             rd_mux = imr_q;
            SEL_PEND:             rd_mux = pend_q;
            SEL_CTRL:             rd_mux = ctrl_q & CTRL_RD_MASK;
            SEL_TGT:              rd_mux = tgt_q;
            default:              rd_mux = '0;
        endcase
    end

    // Registered slave response: ack, data and error one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o   <= 1'b0;
            err_o   <= 1'b0;
            rdata_o <= '0;
            sel_q   <= SEL_NONE;
            rd_q    <= 1'b0;
        end else begin
            ack_o   <= req_i;
            err_o   <= req_i && (sel == SEL_NONE);
            rdata_o <= rd ? rd_mux : '0;
            sel_q   <= sel;
            rd_q    <= rd;
        end
    end

    assign push_o      = (enabled != '0) && !ctrl_q[INHIB_B];
    assign push_word_o = tgt_q;

    AST_PEND_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i != '0) |=> ((pend_q & $past(rise_i)) == $past(rise_i))); // R3
    AST_REQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irr_q & ~$past(irr_q) & ~$past(rise_i & imr_q)) == '0)); // R4
    AST_REQ_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_REQ) |=> (irr_q == ($past(irr_q) | $past(rise_i & imr_q)))); // R2
    AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && rd_q && sel_q == SEL_CTRL) |-> ((rdata_o & ~CTRL_RD_MASK) == '0)); // R6
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && err_o) |-> (rdata_o == '0)); // R10
    AST_BAD_MASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bad_mask_o |=> bad_mask_o); // R11

endmodule

// File: rtl/irq_msg_fifo.sv
// Message queue: holds target-register snapshots in arrival order and
// offers the oldest on a valid/ready port. A push while full is dropped
// and raises a sticky overflow flag. Assumes DEPTH >= 1.
module irq_msg_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    output logic         valid_o,
    output logic [W-1:0] data_o,
    input  logic         ready_i,
    output logic         ovf_o
);

    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          full, do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push_i && !full;
    assign do_pop  = valid_o && ready_i;
    assign valid_o = (cnt_q != '0);
    assign data_o  = mem[rd_q];

    // Storage write at the tail.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= push_data_i;
    end

    // Pointer and occupancy bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + PW'(1);
            if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + PW'(1);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    // Sticky overflow on a push that finds the queue full.
    always_ff @(posedge clk) begin
        if (!rst_n)              ovf_o <= 1'b0;
        else if (push_i && full) ovf_o <= 1'b1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH)); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o); // R9
    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(data_o))); // R8

endmodule

// File: rtl/irq_msg_agg.sv
// Top: 32-line interrupt collector. Line rises are latched in the register
// bank and each cycle with an enabled rise queues one aligned message
// write. Assumes all inputs are synchronous to clk.
module irq_msg_agg
    import irq_agg_pkg::*;
#(
    parameter logic [31:0] TGT_BASE = 32'hFFFE_0000,
    parameter int unsigned Q_DEPTH  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] irq_i,
    input  logic        bus_req_i,
    input  logic        bus_we_i,
    input  logic [7:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic        bus_ack_o,
    output logic [31:0] bus_rdata_o,
    output logic        bus_err_o,
    output logic        msg_valid_o,
    output logic [31:0] msg_addr_o,
    output logic [31:0] msg_data_o,
    input  logic        msg_ready_i,
    output logic        bad_mask_o,
    output logic        msg_ovf_o
);

    logic [DATA_W-1:0] rise, push_word, head;
    logic              push;

    irq_rise_det #(.N(DATA_W)) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (irq_i),
        .rise_o (rise)
    );

    irq_agg_regs #(.TGT_BASE(TGT_BASE)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (bus_req_i),
        .we_i        (bus_we_i),
        .addr_i      (bus_addr_i),
        .wdata_i     (bus_wdata_i),
        .rise_i      (rise),
        .ack_o       (bus_ack_o),
        .rdata_o     (bus_rdata_o),
        .err_o       (bus_err_o),
        .push_o      (push),
        .push_word_o (push_word),
        .bad_mask_o  (bad_mask_o)
    );

    irq_msg_fifo #(.W(DATA_W), .DEPTH(Q_DEPTH)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_data_i (push_word),
        .valid_o     (msg_valid_o),
        .data_o      (head),
        .ready_i     (msg_ready_i),
        .ovf_o       (msg_ovf_o)
    );

    // Split the queued target snapshot into aligned address and line code.
    assign msg_addr_o = {head[DATA_W-1:CODE_W], {CODE_W{1'b0}}};
    assign msg_data_o = {{(DATA_W-CODE_W){1'b0}}, head[CODE_W-1:0]};

endmodule

// File: tb/sim_irq_msg_agg.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module sim_irq_msg_agg;

    localparam logic [31:0] BASE = 32'h0012_3400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq = '0;
    logic        req = 1'b0, we = 1'b0, ready = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        ack, err, mvalid, badm, ovf;
    logic [31:0] rdata, maddr, mdata;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    irq_msg_agg #(.TGT_BASE(BASE), .Q_DEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_i(irq),
        .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_ack_o(ack), .bus_rdata_o(rdata), .bus_err_o(err),
        .msg_valid_o(mvalid), .msg_addr_o(maddr), .msg_data_o(mdata),
        .msg_ready_i(ready), .bad_mask_o(badm), .msg_ovf_o(msg_ovf_unused_n)
    );
    logic msg_ovf_unused_n;
    assign ovf = msg_ovf_unused_n;

    task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    // One slave access; results sampled at the falling edge after the strobe edge.
    task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic e);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        rd = rdata; e = err;
        req = 1'b0; we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] r; logic e;
        bus(1'b1, a, d, r, e);
    endtask

    task automatic rd_chk(input string what, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] r; logic e;
        bus(1'b0, a, 32'h0, r, e);
        check(what, r, exp);
    endtask

    // Raise a line for one cycle; returns at the falling edge after the rise edge.
    task automatic pulse(input int n);
        @(negedge clk); irq[n] = 1'b1;
        @(posedge clk);
        @(negedge clk); irq[n] = 1'b0;
    endtask

    // Accept the head message for exactly one cycle.
    task automatic pop();
        @(negedge clk); ready = 1'b1;
        @(posedge clk);
        @(negedge clk); ready = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 req reset", rdata, 32'h0);
        check("R1 msg_valid reset", {31'b0, mvalid}, 32'h0);
        check("R1 flags reset", {30'b0, badm, ovf}, 32'h0);
        rd_chk("R1 mask reset", 8'h04, 32'h0);
        rd_chk("R1 pend reset", 8'h08, 32'h0);
        rd_chk("R1 ctrl reset", 8'h0C, 32'h0);
        rd_chk("R1 target reset", 8'h10, BASE + 32'd3);
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R2 write to req ignored", 8'h00, 32'h0);
    endtask

    task automatic t_edge();
        wr(8'h04, 32'h0000_0020);
        wr(8'h10, 32'h1234_5677);
        @(negedge clk); irq[5] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R5 msg valid", {31'b0, mvalid}, 32'h1);
        check("R5 msg addr", maddr, 32'h1234_5660);
        check("R5 msg data", mdata, 32'h0000_0017);
        pop();
        repeat (3) @(negedge clk);
        check("R3 held line no second msg", {31'b0, mvalid}, 32'h0);
        irq[5] = 1'b0;
        rd_chk("R4 enabled line latched", 8'h00, 32'h0000_0020);
        pulse(9);
        check("R4 masked line no msg", {31'b0, mvalid}, 32'h0);
        rd_chk("R4 masked line not in req", 8'h00, 32'h0000_0020);
        rd_chk("R3 pending has both lines", 8'h08, 32'h0000_0220);
        rd_chk("R7 pending cleared by read", 8'h08, 32'h0);
        wr(8'h14, 32'h0000_0020);
        rd_chk("R12 alias cleared req", 8'h00, 32'h0);
        rd_chk("R12 alias reads req", 8'h14, 32'h0);
        pulse(7);
        wr(8'h08, 32'h0);
        rd_chk("R7 pending cleared by write", 8'h08, 32'h0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        irq[21] = 1'b1; req = 1'b1; we = 1'b0; addr = 8'h08;
        @(posedge clk);
        @(negedge clk);
        check("R7 read returns old pending", rdata, 32'h0);
        req = 1'b0; irq[21] = 1'b0;
        rd_chk("R7 same-cycle rise kept", 8'h08, 32'h0020_0000);
    endtask

    task automatic t_inhibit();
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_chk("R6 ctrl reads bit 8 only", 8'h0C, 32'h0000_0100);
        wr(8'h04, 32'h0000_2000);
        pulse(13);
        check("R6 inhibited no msg", {31'b0, mvalid}, 32'h0);
        wr(8'h00, 32'h0);
        rd_chk("R2 req unchanged by write", 8'h00, 32'h0000_2000);
        wr(8'h0C, 32'h0);
        rd_chk("R6 ctrl cleared", 8'h0C, 32'h0);
    endtask

    task automatic t_queue();
        wr(8'h04, 32'h0001_0000);
        for (int k = 0; k < 5; k++) begin
            wr(8'h10, 32'hA000_0000 + 32'(k) * 32'h40 + 32'(k));
            pulse(16);
            if (k == 3) check("R9 no overflow at depth", {31'b0, ovf}, 32'h0);
        end
        check("R9 overflow flag", {31'b0, ovf}, 32'h1);
        repeat (2) @(negedge clk);
        check("R8 head stable while stalled", maddr, 32'hA000_0000);
        for (int k = 0; k < 4; k++) begin
            check("R8 order valid", {31'b0, mvalid}, 32'h1);
            check("R8 order addr", maddr, 32'hA000_0000 + 32'(k) * 32'h40);
            check("R8 order data", mdata, 32'(k));
            pop();
        end
        check("R9 dropped message absent", {31'b0, mvalid}, 32'h0);
    endtask

    task automatic t_undecoded();
        logic [31:0] r; logic e;
        bus(1'b0, 8'h18, 32'h0, r, e);
        check("R10 undecoded err", {31'b0, e}, 32'h1);
        check("R10 undecoded data", r, 32'h0);
        bus(1'b1, 8'h40, 32'hFFFF_FFFF, r, e);
        check("R10 undecoded write err", {31'b0, e}, 32'h1);
        bus(1'b0, 8'h10, 32'h0, r, e);
        check("R10 decoded no err", {31'b0, e}, 32'h0);
    endtask

    task automatic t_mask_legal();
        wr(8'h04, 32'h043F_63A0);
        check("R11 legal set no flag", {31'b0, badm}, 32'h0);
        wr(8'h04, 32'hFFFF_FFFF);
        check("R11 all ones no flag", {31'b0, badm}, 32'h0);
        wr(8'h04, 32'h0000_0001);
        check("R11 illegal flag", {31'b0, badm}, 32'h1);
        rd_chk("R11 illegal value stored", 8'h04, 32'h0000_0001);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edge();
        t_same_cycle();
        t_inhibit();
        t_queue();
        t_undecoded();
        t_mask_legal();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule